// File: doc/BRIEF.md
# Trigger-Qualified Window Watchdog

This block supervises a processor that must toggle a trigger line at a steady rate. A free-running time-base counter, clocked by the supervision clock, measures the interval between successive rising edges of the trigger. Each edge restarts that counter. The edge is graded as in-window or out-of-window according to the count it finds. A small saturating score counter gathers these grades. The score rises on each in-window edge and falls on each out-of-window edge. A status flag, the watchdog-OK output, turns on only when the score reaches its top value. It turns off again only when the score drains to zero, so a single late or early trigger does not drop the status.

Two conditions bypass the scoring and force the safe state at once: a silence on the trigger line that lasts a full timeout period, and an external oscillator-fault flag. In both cases the score is cleared and the OK output is withdrawn. While the trigger stays silent, the timeout recurs every period. The fault flag also holds the time base at zero, so that a stalled time base cannot freeze a stale OK state. The trigger is asynchronous to the supervision clock and is resynchronised inside the block. The fault flag is assumed to be synchronous to the clock already.

Top module: `trig_window_wdog`

## Requirements
- R1: A synchronous active-low reset clears the time base, the synchroniser and the score, and drives `wd_ok_o` to 0 at the first clock edge with reset low.
- R2: `trig_i` passes through a two-stage synchroniser. A rising edge first sampled high at clock edge k is acted on at clock edge k+2. A trigger held high is counted as a single edge, however long it stays high.
- R3: The time base reads 0 right after an edge is acted on and then rises by 1 per clock, so edges acted on S clocks apart find the count S-1. An edge is in-window when that count lies in [WIN_LO, WIN_HI], bounds included (defaults 40 and 120). Any other count makes it out-of-window.
- R4: The score moves by +1 for an in-window edge and by -1 for an out-of-window edge. It stays within 0 to QUAL_TOP (default 3) and saturates at both ends.
- R5: `wd_ok_o` becomes 1 in the clock edge that brings the score to QUAL_TOP, and not before.
- R6: `wd_ok_o` keeps its value while the score lies strictly between 0 and QUAL_TOP. It drops to 0 only when the score reaches 0.
- R7: If the time base reaches TIMEOUT-1 (default 249) and no edge is acted on in that clock, the score is cleared, `wd_ok_o` goes to 0 and the time base restarts from 0. This repeats every TIMEOUT clocks while the trigger stays silent. An edge acted on at count TIMEOUT-1 is graded as out-of-window and is not treated as a timeout.
- R8: While `osc_fault_i` is 1, the score is held at 0, `wd_ok_o` is 0, the time base is held at 0, and trigger edges have no effect. After the flag is released, scoring starts again from a score of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervision time-base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_i | input | 1 | Trigger from the supervised processor, asynchronous |
| osc_fault_i | input | 1 | Oscillator-fault flag, synchronous, active high |
| wd_ok_o | output | 1 | Watchdog-OK status, registered |

## Verification
The trigger is driven at a steady in-window rate, at rates that are too fast or too slow, and at spacings that put the count exactly on each window bound and one count outside it. These patterns separate the window comparison from the scoring. Alternating runs of good and bad edges separate saturation from plain counting, and setting at the top from clearing at zero. Spacings of exactly the timeout and one clock more show which of edge and timeout has priority. Long silence, a trigger held high, a fault pulse with triggers under it, and a mid-run reset show that each forced path overrides the scoring and that scoring restarts from zero afterwards.

// File: rtl/wdw_pkg.sv
// Shared types for the trigger-qualified window watchdog.
package wdw_pkg;

    // Grade given to the trigger edge acted on in the current clock.
    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,   // no edge this clock
        VERD_GOOD = 2'd1,   // edge found the count inside the window
        VERD_BAD  = 2'd2    // edge found the count outside the window
    } verdict_e;

endpackage

// File: rtl/wdw_trig_edge.sv
// Trigger resynchroniser and rising-edge detector.
// Assumes trig_i is asynchronous to clk. It produces a one-clock pulse
// for each rising edge, SYNC_STAGES clocks after the edge is first sampled.
module wdw_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic trig_rise_o
);

    // Synchroniser stages plus one delay stage for edge detection.
    logic [SYNC_STAGES:0] chain;

    // Shift the sampled trigger down the chain; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[SYNC_STAGES-1:0], trig_i};
        end
    end

    // Rising edge: newest synchronised sample high, the one before it low.
    always_comb begin
        trig_rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    end

endmodule

// File: rtl/wdw_timebase.sv
// Interval time base with window grading and missing-trigger timeout.
// Assumes osc_fault_i is synchronous. The counter restarts on every
// acted edge, on a timeout and while a fault is present. The edge wins
// over a timeout that falls in the same clock.
module wdw_timebase
    import wdw_pkg::*;
#(
    parameter int TIMEOUT = 250,
    parameter int WIN_LO  = 40,
    parameter int WIN_HI  = 120,
    localparam int TB_W   = $clog2(TIMEOUT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            osc_fault_i,
    input  logic            trig_rise_i,
    output logic [TB_W-1:0] tb_cnt_o,
    output verdict_e        verdict_o,
    output logic            timeout_o
);

    localparam logic [TB_W-1:0] LAST_C = TB_W'(TIMEOUT - 1);

    logic in_window;

    // Compare the running count against the inclusive window bounds.
    always_comb begin
        in_window = (int'(tb_cnt_o) >= WIN_LO) && (int'(tb_cnt_o) <= WIN_HI);
    end

    // Grade the edge and flag a timeout; a fault suppresses both.
    always_comb begin
        verdict_o = VERD_NONE;
        timeout_o = 1'b0;
        if (!osc_fault_i) begin
            if (trig_rise_i) begin
                verdict_o = in_window ? VERD_GOOD : VERD_BAD;
            end else if (tb_cnt_o == LAST_C) begin
                timeout_o = 1'b1;
            end
        end
    end

    // Advance the interval counter or restart it from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_cnt_o <= '0;
        end else if (osc_fault_i || trig_rise_i || timeout_o) begin
            tb_cnt_o <= '0;
        end else begin
            tb_cnt_o <= tb_cnt_o + TB_W'(1);
        end
    end

endmodule

// File: rtl/wdw_qualifier.sv
// Saturating score counter and the watchdog-OK status flag.
// Assumes at most one verdict per clock. The flag is set when the score
// reaches QUAL_TOP and cleared when it reaches zero, giving hysteresis.
module wdw_qualifier
    import wdw_pkg::*;
#(
    parameter int QUAL_TOP = 3,
    localparam int Q_W     = $clog2(QUAL_TOP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           osc_fault_i,
    input  logic           timeout_i,
    input  verdict_e       verdict_i,
    output logic [Q_W-1:0] score_o,
    output logic           ok_o
);

    localparam logic [Q_W-1:0] TOP_C = Q_W'(QUAL_TOP);

    logic [Q_W-1:0] score_nxt;
    logic           ok_nxt;

    // Work out the next score and flag from the verdict and forced clears.
    always_comb begin
        score_nxt = score_o;
        ok_nxt    = ok_o;
        if (osc_fault_i || timeout_i) begin
            score_nxt = '0;
        end else begin
            case (verdict_i)
                VERD_GOOD: if (score_o != TOP_C) score_nxt = score_o + Q_W'(1);
                VERD_BAD:  if (score_o != '0)    score_nxt = score_o - Q_W'(1);
                default:   score_nxt = score_o;
            endcase
        end
        if (score_nxt == TOP_C) begin
            ok_nxt = 1'b1;
        end else if (score_nxt == '0) begin
            ok_nxt = 1'b0;
        end
    end

    // Register the score and the status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_o <= '0;
            ok_o    <= 1'b0;
        end else begin
            score_o <= score_nxt;
            ok_o    <= ok_nxt;
        end
    end

endmodule

// File: rtl/trig_window_wdog.sv
// Top level of the trigger-qualified window watchdog.
// It chains the resynchroniser, the interval time base and the score
// qualifier. Assumes WIN_LO <= WIN_HI < TIMEOUT-1 and SYNC_STAGES >= 1.
module trig_window_wdog
    import wdw_pkg::*;
#(
    parameter int TIMEOUT     = 250,
    parameter int WIN_LO      = 40,
    parameter int WIN_HI      = 120,
    parameter int QUAL_TOP    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic osc_fault_i,
    output logic wd_ok_o
);

    localparam int TB_W = $clog2(TIMEOUT);
    localparam int Q_W  = $clog2(QUAL_TOP + 1);

    logic            trig_rise;
    logic [TB_W-1:0] tb_cnt;
    verdict_e        verdict;
    logic            timeout;
    logic [Q_W-1:0]  score;

    wdw_trig_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) edge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig_i),
        .trig_rise_o (trig_rise)
    );

    wdw_timebase #(
        .TIMEOUT (TIMEOUT),
        .WIN_LO  (WIN_LO),
        .WIN_HI  (WIN_HI)
    ) tbase_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_fault_i (osc_fault_i),
        .trig_rise_i (trig_rise),
        .tb_cnt_o    (tb_cnt),
        .verdict_o   (verdict),
        .timeout_o   (timeout)
    );

    wdw_qualifier #(
        .QUAL_TOP (QUAL_TOP)
    ) qual_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_fault_i (osc_fault_i),
        .timeout_i   (timeout),
        .verdict_i   (verdict),
        .score_o     (score),
        .ok_o        (wd_ok_o)
    );

endmodule

// File: rtl/wdw_checker.sv
// Property checker for the window watchdog, bound to the top level.
// Observes the edge pulse, verdict, time base, score and status output.
module wdw_checker
    import wdw_pkg::*;
#(
    parameter int TIMEOUT  = 250,
    parameter int QUAL_TOP = 3,
    localparam int TB_W    = $clog2(TIMEOUT),
    localparam int Q_W     = $clog2(QUAL_TOP + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            osc_fault_i,
    input logic            wd_ok_o,
    input logic            trig_rise,
    input logic [TB_W-1:0] tb_cnt,
    input verdict_e        verdict,
    input logic            timeout,
    input logic [Q_W-1:0]  score
);

    localparam logic [Q_W-1:0] TOP_C = Q_W'(QUAL_TOP);

    // R1: reset clears the score and the status
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!wd_ok_o && score == '0));

    // R2: an edge pulse lasts a single clock
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise);

    // R4: saturation at the top
    a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (score == TOP_C && verdict == VERD_GOOD) |=> score == TOP_C);

    // R4: saturation at zero
    a_r4_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (score == '0 && verdict == VERD_BAD) |=> score == '0);

    // R4: single step up on a good edge below the top
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (score != TOP_C && verdict == VERD_GOOD) |=> score == $past(score) + Q_W'(1));

    // R5: a full score always shows as OK
    a_r5_set_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        score == TOP_C |-> wd_ok_o);

    // R6: an empty score never shows as OK
    a_r6_clear_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        score == '0 |-> !wd_ok_o);

    // R6: no verdict and no forced clear leaves state unchanged
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERD_NONE && !timeout && !osc_fault_i) |=> ($stable(wd_ok_o) && $stable(score)));

    // R7: timeout forces the safe state
    a_r7_timeout_safe: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (!wd_ok_o && score == '0 && tb_cnt == '0));

    // R7: the time base never passes its last count
    a_r7_tb_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tb_cnt) < TIMEOUT);

    // R8: a fault forces the safe state and holds the time base
    a_r8_fault_safe: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fault_i |=> (!wd_ok_o && score == '0 && tb_cnt == '0));

endmodule

bind trig_window_wdog wdw_checker #(
    .TIMEOUT  (TIMEOUT),
    .QUAL_TOP (QUAL_TOP)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_fault_i (osc_fault_i),
    .wd_ok_o     (wd_ok_o),
    .trig_rise   (trig_rise),
    .tb_cnt      (tb_cnt),
    .verdict     (verdict),
    .timeout     (timeout),
    .score       (score)
);

// File: tb/trig_window_wdog_tb_top.sv
// Bench for the window watchdog: behavioural reference model compared
// with the status output on every clock, plus targeted scenario checks.
module trig_window_wdog_tb_top;

    localparam int T_LIM = 250;
    localparam int LO    = 40;
    localparam int HI    = 120;
    localparam int QMAX  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic osc = 1'b0;
    logic wd_ok;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int m_tb = 0;
    int m_q = 0;
    bit m_ok = 1'b0;
    bit h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    trig_window_wdog dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .osc_fault_i (osc),
        .wd_ok_o     (wd_ok)
    );

    // Behavioural model of the requirements, evaluated at each rising edge
    always @(posedge clk) begin
        bit rise_now;
        bit good;
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_tb = 0; m_q = 0; m_ok = 0;
        end else begin
            rise_now = h2 && !h3;
            if (osc) begin
                m_tb = 0; m_q = 0; m_ok = 0;
            end else if (rise_now) begin
                good = (m_tb >= LO) && (m_tb <= HI);
                m_tb = 0;
                if (good) begin
                    if (m_q < QMAX) m_q++;
                end else if (m_q > 0) begin
                    m_q--;
                end
                if (m_q == QMAX) m_ok = 1;
                if (m_q == 0) m_ok = 0;
            end else if (m_tb == T_LIM - 1) begin
                m_tb = 0; m_q = 0; m_ok = 0;
            end else begin
                m_tb++;
            end
            h3 = h2; h2 = h1; h1 = trig;
        end
    end

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (wd_ok !== m_ok) begin
                n_fail++;
                $display("FAIL %s cycle %0d: wd_ok_o actual %b expected %b",
                         cur_req, cyc, wd_ok, m_ok);
            end
        end
    end

    // Watchdog on the run length
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run not finished, actual %0d cycles expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check_ok(input logic exp, input string req);
        n_checks++;
        if (wd_ok !== exp) begin
            n_fail++;
            $display("FAIL %s: wd_ok_o actual %b expected %b", req, wd_ok, exp);
        end
    endtask

    // n trigger rises spaced sp clocks, each preceded by sp-1 low clocks
    task automatic pulses(input int n, input int sp);
        for (int i = 0; i < n; i++) begin
            repeat (sp - 1) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
        end
    endtask

    // Let the last edge pass the synchroniser
    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_ok(1'b0, "R1 reset state");
        rst_n = 1'b1;

        // R4: a wrong edge at score 0 stays at 0
        cur_req = "R4";
        pulses(1, 20); settle();
        check_ok(1'b0, "R4 low saturation");

        // R5: two good edges are not enough, the third sets OK
        cur_req = "R5";
        pulses(2, 80); settle();
        check_ok(1'b0, "R5 score 2 not yet OK");
        pulses(1, 80); settle();
        check_ok(1'b1, "R5 set at top");

        // R6 / R4: saturation, then hysteresis on the way down
        cur_req = "R6";
        pulses(3, 80);
        pulses(1, 20); settle();
        check_ok(1'b1, "R6 one wrong edge keeps OK");
        pulses(2, 20); settle();
        check_ok(1'b0, "R4 saturated score drains after three wrong edges");
        pulses(1, 80); settle();
        check_ok(1'b0, "R6 score 1 does not set OK");

        // R3: window bounds (spacing S gives count S-1)
        cur_req = "R3";
        pulses(1, 80);
        pulses(1, LO + 1); settle();
        check_ok(1'b1, "R3 count at lower bound is in-window");
        pulses(1, 80);
        pulses(1, LO);
        pulses(1, HI + 2);
        pulses(1, LO); settle();
        check_ok(1'b0, "R3 counts just outside bounds are out-of-window");
        pulses(1, 80);
        pulses(2, HI + 1); settle();
        check_ok(1'b1, "R3 count at upper bound is in-window");

        // R7: edge on the last count beats the timeout; a later edge loses
        cur_req = "R7";
        pulses(1, 80);
        pulses(1, T_LIM); settle();
        check_ok(1'b1, "R7 edge at last count graded, no timeout");
        pulses(1, T_LIM + 1); settle();
        check_ok(1'b0, "R7 timeout clears OK");
        repeat (3 * T_LIM) @(negedge clk);
        check_ok(1'b0, "R7 repeated timeout while silent");

        // R8: fault clears, masks edges, scoring restarts from zero
        cur_req = "R8";
        pulses(4, 80); settle();
        check_ok(1'b1, "R8 OK before fault");
        osc = 1'b1;
        @(negedge clk);
        check_ok(1'b0, "R8 fault clears OK");
        pulses(3, 80); settle();
        check_ok(1'b0, "R8 edges under fault have no effect");
        osc = 1'b0;
        pulses(2, 80); settle();
        check_ok(1'b0, "R8 score restarted from zero after fault");
        pulses(1, 80); settle();
        check_ok(1'b1, "R8 recovery to OK");

        // R2: a trigger held high counts once
        cur_req = "R2";
        repeat (79) @(negedge clk);
        trig = 1'b1;
        repeat (30) @(negedge clk);
        check_ok(1'b1, "R2 held trigger counted once");
        repeat (30) @(negedge clk);
        trig = 1'b0;
        settle();

        // R1: reset in mid-run
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        check_ok(1'b0, "R1 reset clears OK");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule